// File: doc/BRIEF.md
# DRAM Address De-hash and Normalizer

This block accepts a packed DRAM error address (stack ID, pseudochannel, row, bank and column in one 28-bit word) and produces a normalized linear address. It works in two register stages.

The first stage removes the parity-based XOR hashing that the memory controller applied to the four bank bits and to the pseudochannel bit. The two stack-ID bits act as two extra bank bits for the pseudochannel hash.

The second stage places every column, bank, row, pseudochannel and stack-ID bit at a bit position chosen by configuration. The result is registered with a valid flag. The de-hashed bank and pseudochannel values are also presented for debug.

Configuration is loaded through a simple write port. It must be set up while no conversion is in flight.

Top module: `dram_addr_norm`

## Requirements
- R1: The packed input is read as stack ID [27:26], pseudochannel [25], row [24:10], bank [9:6], column [5:1]; bit 0 must be zero. With every hash enable clear, `out_bank` and `out_pc` equal the input bank and pseudochannel fields.
- R2: Config word i (i = 0..3) holds the hash for bank bit i: enable in bit 0, a column mask in bits 13:1 (bit 1 pairs with column bit 0), and a row mask in bits 31:14 (bit 14 pairs with row bit 0). When enabled, bank bit i is XORed with parity(column AND column mask) XOR parity(row AND row mask).
- R3: Config word 4 holds the pseudochannel hash in the same layout, and word 5 bits 5:0 hold a 6-bit extra mask. When enabled, the pseudochannel bit is also XORed with the parity of {stack ID, de-hashed bank} AND that mask.
- R4: A hash word whose enable bit is 0 leaves its bank or pseudochannel bit unchanged, whatever its masks hold.
- R5: Column bit k lands at position 2 + word 7 bits [4k+3:4k]. Bank bit k lands at position 5 + word 8 bits [4k+3:4k].
- R6: Word 6 bits 3:0 plus 10 give the low-row count L, and word 6 bits 7:4 give the high-row count H. Row bit j < L lands at 12 + word 6 bits [11:8] + j. Row bit j with L <= j < L+H lands at 24 + word 6 bits [15:12] + (j - L). Other row bits are not placed.
- R7: The pseudochannel bit lands at 5 + word 6 bits [19:16]. Stack-ID bit 0 lands at 5 + word 8 bits [20:16]. Stack-ID bit 1 lands at 5 + word 8 bits [28:24].
- R8: Every output bit that no field bit reaches is zero, so bits 1:0 are always zero. Field bits that reach the same position are ORed together.
- R9: A placed bit whose position is 40 or more is dropped, and `out_err` is raised for that result whatever the bit's value.
- R10: After reset `out_valid` is 0. A transfer accepted at a clock edge gives `out_valid` high, with its result, for exactly one cycle after the second following edge. Back-to-back inputs give back-to-back outputs.
- R11: `in_ready` is low while `cfg_we` is high. A configuration write made while a conversion sits in the first stage is ignored.
- R12: Writes to config indexes 9 to 15 are ignored. A write at an idle time changes the results of all later conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Packed address valid |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | 28 | Packed DRAM address |
| out_valid | output | 1 | Normalized result valid |
| out_addr | output | 40 | Normalized address |
| out_err | output | 1 | A placed bit fell outside the output width |
| out_bank | output | 4 | De-hashed bank bits |
| out_pc | output | 1 | De-hashed pseudochannel bit |

## Verification
A wrong first-stage bit shows up two edges after acceptance in two places: on `out_bank` or `out_pc`, and as a misplaced bit in `out_addr`. A corrupted configuration word shows up in every later result. A broken stage-valid chain shows as a missing, late or repeated `out_valid` pulse, visible within the same two-cycle window. Sweeps over pseudo-random addresses under several configurations compare each result with an arithmetic model. These configurations cover hashing off, masks with the enable clear, split rows and out-of-range placements.

// File: rtl/dan_pkg.sv
package dan_pkg;
  localparam int PK_W       = 28;
  localparam int COL_W      = 5;
  localparam int BANK_W     = 4;
  localparam int ROW_W      = 15;
  localparam int SID_W      = 2;
  localparam int CMASK_W    = 13;
  localparam int RMASK_W    = 18;
  localparam int PCM_W      = BANK_W + SID_W;
  localparam int SEL_W      = 4;
  localparam int SIDSEL_W   = 5;
  localparam int POS_W      = 7;
  localparam int CFG_AW     = 4;
  localparam int CFG_DW     = 32;

  localparam int COL_LSB    = 1;
  localparam int BANK_LSB   = COL_LSB + COL_W;
  localparam int ROW_LSB    = BANK_LSB + BANK_W;
  localparam int PC_BIT     = ROW_LSB + ROW_W;
  localparam int SID_LSB    = PC_BIT + 1;

  localparam int COL_OFS    = 2;
  localparam int BANK_OFS   = 5;
  localparam int SID_OFS    = 5;
  localparam int PC_OFS     = 5;
  localparam int ROWLO_OFS  = 12;
  localparam int ROWHI_OFS  = 24;
  localparam int ROWLO_BASE = 10;

  localparam logic [CFG_AW-1:0] REG_PC_HASH = CFG_AW'(BANK_W);
  localparam logic [CFG_AW-1:0] REG_PC_MASK = CFG_AW'(BANK_W + 1);
  localparam logic [CFG_AW-1:0] REG_ROW     = CFG_AW'(BANK_W + 2);
  localparam logic [CFG_AW-1:0] REG_COL     = CFG_AW'(BANK_W + 3);
  localparam logic [CFG_AW-1:0] REG_BANK    = CFG_AW'(BANK_W + 4);

  typedef struct packed {
    logic [RMASK_W-1:0] rmask;
    logic [CMASK_W-1:0] cmask;
    logic               en;
  } hash_word_t;

  typedef struct packed {
    hash_word_t [BANK_W-1:0]                bank_hash;
    hash_word_t                             pc_hash;
    logic [PCM_W-1:0]                       pc_mask;
    logic [SEL_W-1:0]                       row_lo_cnt;
    logic [SEL_W-1:0]                       row_hi_cnt;
    logic [SEL_W-1:0]                       row_lo_sel;
    logic [SEL_W-1:0]                       row_hi_sel;
    logic [SEL_W-1:0]                       pc_sel;
    logic [COL_W-1:0][SEL_W-1:0]            col_sel;
    logic [BANK_W-1:0][SEL_W-1:0]           bank_sel;
    logic [SID_W-1:0][SIDSEL_W-1:0]         sid_sel;
  } dan_cfg_t;
endpackage

// File: rtl/dan_cfg.sv
module dan_cfg
  import dan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_idx,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic              busy,
  output dan_cfg_t          cfg_o
);
  dan_cfg_t cfg_q;
  logic     wr_ok;

  assign wr_ok = wr_en && !busy;
  assign cfg_o = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < BANK_W; i++) begin
        if (wr_idx == CFG_AW'(i)) cfg_q.bank_hash[i] <= hash_word_t'(wr_data);
      end
      case (wr_idx)
        REG_PC_HASH: cfg_q.pc_hash <= hash_word_t'(wr_data);
        REG_PC_MASK: cfg_q.pc_mask <= wr_data[PCM_W-1:0];
        REG_ROW: begin
          cfg_q.row_lo_cnt <= wr_data[3:0];
          cfg_q.row_hi_cnt <= wr_data[7:4];
          cfg_q.row_lo_sel <= wr_data[11:8];
          cfg_q.row_hi_sel <= wr_data[15:12];
          cfg_q.pc_sel     <= wr_data[19:16];
        end
        REG_COL: begin
          for (int k = 0; k < COL_W; k++) cfg_q.col_sel[k] <= wr_data[SEL_W*k +: SEL_W];
        end
        REG_BANK: begin
          for (int k = 0; k < BANK_W; k++) cfg_q.bank_sel[k] <= wr_data[SEL_W*k +: SEL_W];
          cfg_q.sid_sel[0] <= wr_data[20:16];
          cfg_q.sid_sel[1] <= wr_data[28:24];
        end
        default: ;
      endcase
    end
  end

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> $stable(cfg_q));
endmodule

// File: rtl/dan_dehash.sv
module dan_dehash
  import dan_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc,
  input  logic [COL_W-1:0]        f_col,
  input  logic [BANK_W-1:0]       f_bank,
  input  logic [ROW_W-1:0]        f_row,
  input  logic                    f_pc,
  input  logic [SID_W-1:0]        f_sid,
  input  hash_word_t [BANK_W-1:0] bank_hash,
  input  hash_word_t              pc_hash,
  input  logic [PCM_W-1:0]        pc_mask,
  output logic                    s1_valid,
  output logic [COL_W-1:0]        s1_col,
  output logic [ROW_W-1:0]        s1_row,
  output logic [SID_W-1:0]        s1_sid,
  output logic [BANK_W-1:0]       s1_bank,
  output logic                    s1_pc
);
  logic [BANK_W-1:0] bank_dh;
  logic              pc_dh;

  function automatic logic mask_par(input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r,
                                    input hash_word_t h);
    return (^(CMASK_W'(c) & h.cmask)) ^ (^(RMASK_W'(r) & h.rmask));
  endfunction

  for (genvar i = 0; i < BANK_W; i++) begin : g_bank
    assign bank_dh[i] = f_bank[i] ^ (bank_hash[i].en & mask_par(f_col, f_row, bank_hash[i]));

    assert_bank_keep_R4: assert property (@(posedge clk) disable iff (rst)
      (acc && !bank_hash[i].en) |=> (s1_bank[i] == $past(f_bank[i])));
  end

  assign pc_dh = f_pc ^ (pc_hash.en & (mask_par(f_col, f_row, pc_hash)
                                       ^ (^({f_sid, bank_dh} & pc_mask))));

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= acc;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      s1_col  <= f_col;
      s1_row  <= f_row;
      s1_sid  <= f_sid;
      s1_bank <= bank_dh;
      s1_pc   <= pc_dh;
    end
  end

  assert_pc_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && !pc_hash.en) |=> (s1_pc == $past(f_pc)));
endmodule

// File: rtl/dan_scatter.sv
module dan_scatter
  import dan_pkg::*;
#(
  parameter int NA_W = 40
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           s1_valid,
  input  logic [COL_W-1:0]               s1_col,
  input  logic [ROW_W-1:0]               s1_row,
  input  logic [SID_W-1:0]               s1_sid,
  input  logic [BANK_W-1:0]              s1_bank,
  input  logic                           s1_pc,
  input  logic [COL_W-1:0][SEL_W-1:0]    col_sel,
  input  logic [BANK_W-1:0][SEL_W-1:0]   bank_sel,
  input  logic [SID_W-1:0][SIDSEL_W-1:0] sid_sel,
  input  logic [SEL_W-1:0]               row_lo_cnt,
  input  logic [SEL_W-1:0]               row_hi_cnt,
  input  logic [SEL_W-1:0]               row_lo_sel,
  input  logic [SEL_W-1:0]               row_hi_sel,
  input  logic [SEL_W-1:0]               pc_sel,
  output logic                           out_valid,
  output logic [NA_W-1:0]                out_na,
  output logic                           out_err,
  output logic [BANK_W-1:0]              out_bank,
  output logic                           out_pc
);
  logic [NA_W-1:0] na_c;
  logic            err_c;

  always_comb begin
    logic [POS_W-1:0] p;
    logic             hit;
    int               nlo;
    na_c  = '0;
    err_c = 1'b0;
    p     = '0;
    hit   = 1'b0;
    nlo   = ROWLO_BASE + int'(row_lo_cnt);
    for (int k = 0; k < COL_W; k++) begin
      p     = POS_W'(COL_OFS) + POS_W'(col_sel[k]);
      na_c  = na_c | (NA_W'(s1_col[k]) << p);
      err_c = err_c | (int'(p) >= NA_W);
    end
    for (int k = 0; k < BANK_W; k++) begin
      p     = POS_W'(BANK_OFS) + POS_W'(bank_sel[k]);
      na_c  = na_c | (NA_W'(s1_bank[k]) << p);
      err_c = err_c | (int'(p) >= NA_W);
    end
    for (int k = 0; k < SID_W; k++) begin
      p     = POS_W'(SID_OFS) + POS_W'(sid_sel[k]);
      na_c  = na_c | (NA_W'(s1_sid[k]) << p);
      err_c = err_c | (int'(p) >= NA_W);
    end
    p     = POS_W'(PC_OFS) + POS_W'(pc_sel);
    na_c  = na_c | (NA_W'(s1_pc) << p);
    err_c = err_c | (int'(p) >= NA_W);
    for (int j = 0; j < ROW_W; j++) begin
      hit = 1'b0;
      if (j < nlo) begin
        p   = POS_W'(ROWLO_OFS) + POS_W'(row_lo_sel) + POS_W'(j);
        hit = 1'b1;
      end else if ((j - nlo) < int'(row_hi_cnt)) begin
        p   = POS_W'(ROWHI_OFS) + POS_W'(row_hi_sel) + POS_W'(j - nlo);
        hit = 1'b1;
      end
      if (hit) begin
        na_c  = na_c | (NA_W'(s1_row[j]) << p);
        err_c = err_c | (int'(p) >= NA_W);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      out_na   <= na_c;
      out_err  <= err_c;
      out_bank <= s1_bank;
      out_pc   <= s1_pc;
    end
  end

  assert_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_na[1:0] == 2'b00));

  if (NA_W >= 40) begin : g_range_chk
    assert_no_err_R9: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && row_hi_cnt == '0 && row_lo_sel == '0) |=> !out_err);
  end
endmodule

// File: rtl/dram_addr_norm.sv
module dram_addr_norm
  import dan_pkg::*;
#(
  parameter int NA_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PK_W-1:0]   in_addr,
  output logic              out_valid,
  output logic [NA_W-1:0]   out_addr,
  output logic              out_err,
  output logic [BANK_W-1:0] out_bank,
  output logic              out_pc
);
  dan_cfg_t          cfg;
  logic              acc;
  logic              s1_valid;
  logic [COL_W-1:0]  s1_col;
  logic [ROW_W-1:0]  s1_row;
  logic [SID_W-1:0]  s1_sid;
  logic [BANK_W-1:0] s1_bank;
  logic              s1_pc;

  assign in_ready = !cfg_we;
  assign acc      = in_valid && in_ready;

  dan_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_addr),
    .wr_data (cfg_wdata),
    .busy    (s1_valid),
    .cfg_o   (cfg)
  );

  dan_dehash u_dehash (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .f_col     (in_addr[COL_LSB +: COL_W]),
    .f_bank    (in_addr[BANK_LSB +: BANK_W]),
    .f_row     (in_addr[ROW_LSB +: ROW_W]),
    .f_pc      (in_addr[PC_BIT]),
    .f_sid     (in_addr[SID_LSB +: SID_W]),
    .bank_hash (cfg.bank_hash),
    .pc_hash   (cfg.pc_hash),
    .pc_mask   (cfg.pc_mask),
    .s1_valid  (s1_valid),
    .s1_col    (s1_col),
    .s1_row    (s1_row),
    .s1_sid    (s1_sid),
    .s1_bank   (s1_bank),
    .s1_pc     (s1_pc)
  );

  dan_scatter #(.NA_W(NA_W)) u_scatter (
    .clk        (clk),
    .rst        (rst),
    .s1_valid   (s1_valid),
    .s1_col     (s1_col),
    .s1_row     (s1_row),
    .s1_sid     (s1_sid),
    .s1_bank    (s1_bank),
    .s1_pc      (s1_pc),
    .col_sel    (cfg.col_sel),
    .bank_sel   (cfg.bank_sel),
    .sid_sel    (cfg.sid_sel),
    .row_lo_cnt (cfg.row_lo_cnt),
    .row_hi_cnt (cfg.row_hi_cnt),
    .row_lo_sel (cfg.row_lo_sel),
    .row_hi_sel (cfg.row_hi_sel),
    .pc_sel     (cfg.pc_sel),
    .out_valid  (out_valid),
    .out_na     (out_addr),
    .out_err    (out_err),
    .out_bank   (out_bank),
    .out_pc     (out_pc)
  );

  assert_lat_R10: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##2 out_valid);

  assert_zero_pad_R1: assert property (@(posedge clk) disable iff (rst)
    acc |-> !in_addr[0]);
endmodule

// File: tb/sim_dram_addr_norm.sv
module sim_dram_addr_norm;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [27:0] in_addr;
  logic        out_valid;
  logic [39:0] out_addr;
  logic        out_err;
  logic [3:0]  out_bank;
  logic        out_pc;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] sh [0:8];
  logic [31:0] rng = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  dram_addr_norm u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err),
    .out_bank(out_bank), .out_pc(out_pc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [27:0] a, output logic [39:0] na,
                                output logic er, output logic [3:0] bk, output logic pc);
    logic [4:0]  col;
    logic [14:0] row;
    logic [1:0]  sid;
    logic [63:0] w;
    int          p;
    int          nlo;
    int          nhi;
    col = a[5:1]; bk = a[9:6]; row = a[24:10]; pc = a[25]; sid = a[27:26];
    for (int i = 0; i < 4; i++)
      if (sh[i][0])
        bk[i] = bk[i] ^ (^({8'b0, col} & sh[i][13:1])) ^ (^({3'b0, row} & sh[i][31:14]));
    if (sh[4][0])
      pc = pc ^ (^({8'b0, col} & sh[4][13:1])) ^ (^({3'b0, row} & sh[4][31:14]))
              ^ (^({sid, bk} & sh[5][5:0]));
    w = '0; er = 1'b0;
    for (int k = 0; k < 5; k++) begin
      p = 2 + int'(sh[7][4*k +: 4]);
      if (p >= 40) er = 1'b1; else w[p] = w[p] | col[k];
    end
    for (int k = 0; k < 4; k++) begin
      p = 5 + int'(sh[8][4*k +: 4]);
      if (p >= 40) er = 1'b1; else w[p] = w[p] | bk[k];
    end
    p = 5 + int'(sh[8][20:16]);
    if (p >= 40) er = 1'b1; else w[p] = w[p] | sid[0];
    p = 5 + int'(sh[8][28:24]);
    if (p >= 40) er = 1'b1; else w[p] = w[p] | sid[1];
    p = 5 + int'(sh[6][19:16]);
    if (p >= 40) er = 1'b1; else w[p] = w[p] | pc;
    nlo = 10 + int'(sh[6][3:0]);
    nhi = int'(sh[6][7:4]);
    for (int j = 0; j < 15; j++) begin
      p = -1;
      if (j < nlo) p = 12 + int'(sh[6][11:8]) + j;
      else if (j < nlo + nhi) p = 24 + int'(sh[6][15:12]) + j - nlo;
      if (p >= 40) er = 1'b1;
      else if (p >= 0) w[p] = w[p] | row[j];
    end
    na = w[39:0];
  endfunction

  task automatic cfg_wr(input int idx, input logic [31:0] d, input bit keep);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (keep) sh[idx] = d;
  endtask

  task automatic check_out(input logic [27:0] a, input string tna, input string tbk);
    logic [39:0] na; logic er; logic [3:0] bk; logic pc;
    model(a, na, er, bk, pc);
    chk("R10 out_valid", {63'b0, out_valid}, 64'd1);
    chk({tna, " addr"}, {24'b0, out_addr}, {24'b0, na});
    chk("R9 err", {63'b0, out_err}, {63'b0, er});
    chk({tbk, " bank"}, {60'b0, out_bank}, {60'b0, bk});
    chk({tbk, " pc"}, {63'b0, out_pc}, {63'b0, pc});
  endtask

  task automatic convert(input logic [27:0] a, input string tna, input string tbk);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 early", {63'b0, out_valid}, 64'd0);
    @(negedge clk);
    check_out(a, tna, tbk);
  endtask

  task automatic sweep(input int n, input string tna, input string tbk);
    convert(28'h0, tna, tbk);
    convert(28'hFFF_FFFE, tna, tbk);
    for (int i = 0; i < n; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      convert({rng[27:1], 1'b0}, tna, tbk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) sh[i] = '0;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; in_valid = 1'b0; in_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R10 reset out_valid", {63'b0, out_valid}, 64'd0);
    chk("R11 reset in_ready", {63'b0, in_ready}, 64'd1);

    sweep(40, "R8", "R1");

    cfg_wr(7, 32'h0004_3210, 1);
    cfg_wr(8, 32'h0706_5432, 1);
    cfg_wr(6, 32'h000F_0005, 1);
    sweep(150, "R5 R7", "R1");

    cfg_wr(0, 32'hA5A5_3C3B, 1);
    cfg_wr(1, 32'h1234_5679, 1);
    cfg_wr(2, 32'hFFFF_C001, 1);
    cfg_wr(3, 32'h0000_0041, 1);
    cfg_wr(4, 32'h5A5A_9AB5, 1);
    cfg_wr(5, 32'h0000_003F, 1);
    sweep(200, "R5 R7", "R2 R3");

    cfg_wr(4, 32'h0000_0001, 1);
    cfg_wr(5, 32'h0000_0030, 1);
    sweep(60, "R7", "R3");

    for (int i = 0; i < 5; i++) cfg_wr(i, 32'hFFFF_FFFE, 1);
    cfg_wr(5, 32'h0000_003F, 1);
    sweep(100, "R8", "R4");

    cfg_wr(6, 32'h0001_3250, 1);
    sweep(100, "R6", "R1");
    cfg_wr(6, 32'h0002_4123, 1);
    sweep(100, "R6", "R1");

    cfg_wr(6, 32'h000F_FFFF, 1);
    cfg_wr(8, 32'h1F1F_FFFF, 1);
    sweep(60, "R9", "R1");

    cfg_wr(6, 32'h000F_0005, 1);
    cfg_wr(8, 32'h0706_5432, 1);

    // R10 back-to-back acceptance gives back-to-back results
    @(negedge clk); in_valid = 1'b1; in_addr = 28'h8A5_3C6A;
    @(negedge clk); in_addr = 28'h35A_C392;
    @(negedge clk); in_valid = 1'b0;
    check_out(28'h8A5_3C6A, "R10", "R10");
    @(negedge clk);
    check_out(28'h35A_C392, "R10", "R10");
    @(negedge clk);
    chk("R10 single pulse", {63'b0, out_valid}, 64'd0);

    // R11 write during an in-flight conversion is dropped
    @(negedge clk); in_valid = 1'b1; in_addr = 28'h7B3_D0E4;
    @(negedge clk); in_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'd7; cfg_wdata = 32'h000F_FFFF;
    #1;
    chk("R11 in_ready low", {63'b0, in_ready}, 64'd0);
    @(negedge clk); cfg_we = 1'b0;
    check_out(28'h7B3_D0E4, "R11", "R11");
    convert(28'h7B3_D0E4, "R11", "R11");

    // R12 unmapped index ignored, idle write takes effect
    cfg_wr(12, 32'hFFFF_FFFF, 0);
    convert(28'hC3C_3C3C, "R12", "R12");
    cfg_wr(7, 32'h0002_2100, 1);
    convert(28'hC3C_3C3C, "R12", "R12");
    sweep(30, "R12", "R12");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule